// File: doc/BRIEF.md
# Soft-Decision Quantizer with Deinterleaving Frame Store

This block sits between a demodulator and a soft-decision convolutional decoder. While a frame is being received, each valid 16-bit signed soft metric is reduced to a 3-bit confidence code. The code is written into a frame store of 2144 three-bit entries, in plain arrival order, using a write index that only counts accepted samples. A negative metric stands for a received '1' and a positive one for a received '0'.

Once the frame is complete, the decoder reads the store by information-bit index. Each read returns the two deinterleaved code-bit confidences of that bit, the G1 value and the G2 value. The read address undoes a 67-row by 32-column column-major block interleaver. It also reverses the bit order inside every byte, because bytes go over the air most significant bit first. This way the write side never needs a bit-in-byte counter.

Top module: `soft_deint_buffer`

## Requirements
- R1: Each accepted metric s is stored as a 3-bit code with the default limits W=50, M=150, S=300. The code is 111 when s < -S, 101 when s < -M, 100 when s < -W, 011 when s < W, 010 when s < M, 001 when s < S, and 000 otherwise. W, M and S are parameters.
- R2: Polarity: every metric at or below -(W+1) yields a code whose top bit is 1. Every metric at or above -W yields a code whose top bit is 0. The code 110 is never produced.
- R3: The n-th accepted sample of a frame (counting from 0) is written to store address n.
- R4: A read of pair index k returns two values. rdG1 is the code at address A(2k) and rdG2 is the code at address A(2k+1). Here A(d) = (p/8)*8 + 7 - (p mod 8), with p = (d mod 32)*67 + d/32.
- R5: Read data and rdValid appear one clock after a read request. rdValid is low in any cycle that follows a cycle without a request.
- R6: frameDone goes high on the clock edge that accepts the 2144th sample of a frame. It stays high until the next frameStart, and it is low in the cycle after frameStart.
- R7: Samples offered while frameDone is high are discarded, and the stored frame reads back unchanged.
- R8: After reset, frameDone and rdValid are low. Samples offered before the first frameStart are discarded and never raise frameDone.
- R9: A sample presented in the same cycle as frameStart is stored as sample 0 of the new frame.
- R10: Cycles with sampleValid low store nothing and do not advance the write index, whatever value is on sampleSoft.
- R11: A read request with a pair index of 1072 or more is ignored: rdValid stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Begins a new frame and rewinds the write index |
| sampleValid | input | 1 | sampleSoft carries a metric this cycle |
| sampleSoft | input | 16 | Signed soft metric (negative means '1') |
| frameDone | output | 1 | All 2144 samples of the current frame stored |
| rdReq | input | 1 | Read request |
| rdPair | input | 11 | Information-bit (pair) index to read |
| rdValid | output | 1 | rdG1/rdG2 valid, one cycle after rdReq |
| rdG1 | output | 3 | Confidence code of the first code bit |
| rdG2 | output | 3 | Confidence code of the second code bit |

## Verification
The first sixteen samples of each frame are metrics just inside and just outside every limit, plus both extremes. Each of them must land on the one code its interval calls for, which separates a `<` comparison from a `<=` one and catches a swapped polarity. The rest of each frame is a seeded ramp of metrics. The whole store is read back pair by pair and compared with a model built from the address formula, so any slip in row/column order, G1/G2 pairing or the in-byte reversal shows up as a mismatch at many indices. Sample gaps with junk on the data bus, samples after the frame is full, samples before any frame start, and a second frame with a different seed show whether the write index moves only on accepted samples and whether a new frame fully overwrites the previous one.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrEn;   // store the current quantized sample
    logic rdEn;   // capture a deinterleaved pair
  } sfbStrobes_t;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FILL = 2'd1,
    RX_FULL = 2'd2
  } rxState_t;

endpackage

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
#(
  parameter int DEPTH = 2144,
  parameter int PAIRS = DEPTH / 2,
  parameter int PW    = $clog2(PAIRS),
  parameter int AW    = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          sampleValid,
  input  logic          rdReq,
  input  logic [PW-1:0] rdPair,
  output sfbStrobes_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic          frameDone,
  output logic          rdValid
);

  localparam logic [AW-1:0] LAST_IDX  = AW'(DEPTH - 1);
  localparam logic [PW:0]   PAIR_LIM  = (PW+1)'(PAIRS);

  rxState_t      state;
  logic [AW-1:0] wrCnt;
  logic          accept;
  logic          rdOk;
  logic          rdValidQ;

  always_comb begin
    accept = frameStart ? sampleValid : (sampleValid && (state == RX_FILL));
    rdOk   = rdReq && ({1'b0, rdPair} < PAIR_LIM);
    wrAddr = frameStart ? '0 : wrCnt;
    stb.wrEn = accept;
    stb.rdEn = rdOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      wrCnt    <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= rdOk;
      if (frameStart) begin
        wrCnt <= sampleValid ? AW'(1) : '0;
        state <= RX_FILL;
      end else if (accept) begin
        wrCnt <= wrCnt + AW'(1);
        if (wrCnt == LAST_IDX) begin
          state <= RX_FULL;
        end
      end
    end
  end

  assign frameDone = (state == RX_FULL);
  assign rdValid   = rdValidQ;

endmodule

// File: rtl/sfb_datapath.sv
module sfb_datapath
  import sfb_pkg::*;
#(
  parameter int SW        = 16,
  parameter int CW        = 3,
  parameter int ROWS      = 67,
  parameter int COLS      = 32,
  parameter int TH_WEAK   = 50,
  parameter int TH_MID    = 150,
  parameter int TH_STRONG = 300,
  parameter int DEPTH     = ROWS * COLS,
  parameter int PAIRS     = DEPTH / 2,
  parameter int PW        = $clog2(PAIRS),
  parameter int AW        = PW + 1
) (
  input  logic                 clk,
  input  sfbStrobes_t          stb,
  input  logic [AW-1:0]        wrAddr,
  input  logic signed [SW-1:0] sampleSoft,
  input  logic [PW-1:0]        rdPair,
  output logic [CW-1:0]        rdG1,
  output logic [CW-1:0]        rdG2
);

  localparam int LANES = 2;

  logic [CW-1:0] store [DEPTH];
  logic [CW-1:0] qCode;
  logic [CW-1:0] laneCode [LANES];

  // Seven-level confidence code; negative metric means a received '1'
  function automatic logic [CW-1:0] quantize(input logic signed [SW-1:0] s);
    int v;
    v = int'(s);
    if      (v < -TH_STRONG) return CW'(3'b111);
    else if (v < -TH_MID)    return CW'(3'b101);
    else if (v < -TH_WEAK)   return CW'(3'b100);
    else if (v <  TH_WEAK)   return CW'(3'b011);
    else if (v <  TH_MID)    return CW'(3'b010);
    else if (v <  TH_STRONG) return CW'(3'b001);
    else                     return CW'(3'b000);
  endfunction

  // Deinterleaved index -> arrival-order address (block deinterleave, then
  // reverse the bit position inside the byte because bytes go out MSB first)
  function automatic logic [AW-1:0] arrivalAddr(input logic [AW-1:0] d);
    int row;
    int col;
    int p;
    row = int'(d) / COLS;
    col = int'(d) % COLS;
    p   = col * ROWS + row;
    return AW'((p / 8) * 8 + 7 - (p % 8));
  endfunction

  assign qCode = quantize(sampleSoft);

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      store[wrAddr] <= qCode;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [AW-1:0] deIdx;
    logic [AW-1:0] memIdx;
    logic [CW-1:0] codeQ;
    assign deIdx  = {rdPair, 1'(g)};
    assign memIdx = arrivalAddr(deIdx);
    always_ff @(posedge clk) begin
      if (stb.rdEn) begin
        codeQ <= store[memIdx];
      end
    end
    assign laneCode[g] = codeQ;
  end

  assign rdG1 = laneCode[0];
  assign rdG2 = laneCode[1];

endmodule

// File: rtl/soft_deint_buffer.sv
module soft_deint_buffer
  import sfb_pkg::*;
#(
  parameter int SW        = 16,
  parameter int CW        = 3,
  parameter int ROWS      = 67,
  parameter int COLS      = 32,
  parameter int TH_WEAK   = 50,
  parameter int TH_MID    = 150,
  parameter int TH_STRONG = 300,
  parameter int DEPTH     = ROWS * COLS,
  parameter int PAIRS     = DEPTH / 2,
  parameter int PW        = $clog2(PAIRS),
  parameter int AW        = PW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  input  logic                 sampleValid,
  input  logic signed [SW-1:0] sampleSoft,
  output logic                 frameDone,
  input  logic                 rdReq,
  input  logic [PW-1:0]        rdPair,
  output logic                 rdValid,
  output logic [CW-1:0]        rdG1,
  output logic [CW-1:0]        rdG2
);

  sfbStrobes_t   stb;
  logic [AW-1:0] wrAddr;

  sfb_ctrl #(
    .DEPTH(DEPTH), .PAIRS(PAIRS), .PW(PW), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .sampleValid(sampleValid), .rdReq(rdReq), .rdPair(rdPair),
    .stb(stb), .wrAddr(wrAddr), .frameDone(frameDone), .rdValid(rdValid)
  );

  sfb_datapath #(
    .SW(SW), .CW(CW), .ROWS(ROWS), .COLS(COLS),
    .TH_WEAK(TH_WEAK), .TH_MID(TH_MID), .TH_STRONG(TH_STRONG),
    .DEPTH(DEPTH), .PAIRS(PAIRS), .PW(PW), .AW(AW)
  ) u_dp (
    .clk(clk), .stb(stb), .wrAddr(wrAddr), .sampleSoft(sampleSoft),
    .rdPair(rdPair), .rdG1(rdG1), .rdG2(rdG2)
  );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int CW    = 3,
  parameter int PAIRS = 1072,
  parameter int PW    = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic          frameDone,
  input logic          rdReq,
  input logic [PW-1:0] rdPair,
  input logic          rdValid,
  input logic [CW-1:0] rdG1,
  input logic [CW-1:0] rdG2
);

  localparam logic [PW:0] LIM = (PW+1)'(PAIRS);

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !frameStart) |=> frameDone);

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameDone);

  a_r5_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && ({1'b0, rdPair} < LIM)) |=> rdValid);

  a_r5_no_req_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  a_r11_range_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && ({1'b0, rdPair} >= LIM)) |=> !rdValid);

  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdG1 != CW'(3'b110) && rdG2 != CW'(3'b110)));

endmodule

bind soft_deint_buffer sfb_checker #(
  .CW(CW), .PAIRS(PAIRS), .PW(PW)
) u_sfb_checker (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameDone(frameDone),
  .rdReq(rdReq), .rdPair(rdPair), .rdValid(rdValid),
  .rdG1(rdG1), .rdG2(rdG2)
);

// File: tb/tb_soft_deint_buffer.sv
module tb_soft_deint_buffer;

  localparam int DEPTH = 2144;
  localparam int PAIRS = 1072;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               frameStart = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [15:0] sampleSoft = '0;
  logic               frameDone;
  logic               rdReq = 1'b0;
  logic [10:0]        rdPair = '0;
  logic               rdValid;
  logic [2:0]         rdG1;
  logic [2:0]         rdG2;

  int nChecks = 0;
  int nFails  = 0;
  logic [2:0] model [DEPTH];

  logic signed [15:0] edgeVals [16] = '{
    -16'sd32768, -16'sd301, -16'sd300, -16'sd151, -16'sd150, -16'sd51,
    -16'sd50, 16'sd0, 16'sd49, 16'sd50, 16'sd149, 16'sd150, 16'sd299,
    16'sd300, 16'sd32767, -16'sd1 };
  // Codes required by R1 for edgeVals, written out by hand
  logic [2:0] edgeCodes [16] = '{
    3'b111, 3'b111, 3'b101, 3'b101, 3'b100, 3'b100, 3'b011, 3'b011,
    3'b011, 3'b010, 3'b010, 3'b001, 3'b001, 3'b000, 3'b000, 3'b011 };

  always #5 clk = ~clk;

  soft_deint_buffer dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .sampleValid(sampleValid), .sampleSoft(sampleSoft),
    .frameDone(frameDone), .rdReq(rdReq), .rdPair(rdPair),
    .rdValid(rdValid), .rdG1(rdG1), .rdG2(rdG2)
  );

  function automatic logic [2:0] refCode(input int v);
    if (v < -300) return 3'b111;
    if (v < -150) return 3'b101;
    if (v < -50)  return 3'b100;
    if (v < 50)   return 3'b011;
    if (v < 150)  return 3'b010;
    if (v < 300)  return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic signed [15:0] softOf(input int k, input int seed);
    int v;
    if (k < 16) return edgeVals[k];
    v = ((k * 37 + seed * 101) % 801) - 400;
    return 16'(v);
  endfunction

  function automatic int addrOf(input int d);
    int p;
    p = (d % 32) * 67 + d / 32;
    return (p / 8) * 8 + 7 - (p % 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // R8: reset state, samples before any frameStart are dropped
  task automatic testResetAndIdle();
    check(frameDone == 1'b0, "R8", "frameDone after reset", int'(frameDone), 0);
    check(rdValid == 1'b0, "R8", "rdValid after reset", int'(rdValid), 0);
    for (int k = 0; k < DEPTH + 20; k++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleSoft  = softOf(k, 3);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    check(frameDone == 1'b0, "R8", "frameDone after idle samples", int'(frameDone), 0);
  endtask

  // R3 R6 R9 R10: one frame with gaps carrying junk data
  task automatic sendFrame(input int seed, input int gapEvery);
    @(negedge clk);
    frameStart  = 1'b1;
    sampleValid = 1'b1;
    sampleSoft  = softOf(0, seed);
    model[0]    = refCode(int'(softOf(0, seed)));
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check(frameDone == 1'b0, "R6", "frameDone after frameStart", int'(frameDone), 0);
      end
      frameStart = 1'b0;
      if (gapEvery > 0 && (k % gapEvery) == 0) begin
        sampleValid = 1'b0;
        sampleSoft  = (k % 2 == 0) ? 16'sd32767 : -16'sd32768;
        @(negedge clk);
      end
      sampleValid = 1'b1;
      sampleSoft  = softOf(k, seed);
      model[k]    = refCode(int'(softOf(k, seed)));
      if (k == DEPTH - 1) begin
        check(frameDone == 1'b0, "R6", "frameDone before last sample", int'(frameDone), 0);
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
    check(frameDone == 1'b1, "R6", "frameDone after 2144th sample", int'(frameDone), 1);
  endtask

  // R4 R5 R1 R2 R3: read every pair and compare with the model
  task automatic readAll(input string tag);
    int a1;
    int a2;
    int bad;
    bad = 0;
    for (int k = 0; k < PAIRS; k++) begin
      @(negedge clk);
      rdReq  = 1'b1;
      rdPair = 11'(k);
      a1 = addrOf(2 * k);
      a2 = addrOf(2 * k + 1);
      @(negedge clk);
      rdReq = 1'b0;
      check(rdValid == 1'b1, "R5", "rdValid one cycle after request", int'(rdValid), 1);
      check(rdG1 == model[a1] && rdG2 == model[a2], "R4",
            {tag, " pair G1G2"}, int'({rdG1, rdG2}), int'({model[a1], model[a2]}));
      if (a1 < 16) begin
        check(rdG1 == edgeCodes[a1], "R1", "threshold code G1", int'(rdG1), int'(edgeCodes[a1]));
        check(rdG1[2] == (edgeVals[a1] <= -16'sd51), "R2", "polarity G1",
              int'(rdG1[2]), int'(edgeVals[a1] <= -16'sd51));
      end
      if (a2 < 16) begin
        check(rdG2 == edgeCodes[a2], "R1", "threshold code G2", int'(rdG2), int'(edgeCodes[a2]));
        check(rdG2[2] == (edgeVals[a2] <= -16'sd51), "R2", "polarity G2",
              int'(rdG2[2]), int'(edgeVals[a2] <= -16'sd51));
      end
      if (rdG1 != model[a1]) bad++;
    end
    @(negedge clk);
    check(rdValid == 1'b0, "R5", "rdValid low without request", int'(rdValid), 0);
    check(bad == 0, "R3", {tag, " arrival order G1 mismatches"}, bad, 0);
  endtask

  // R7: samples after a full frame change nothing
  task automatic testOverflow();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleSoft  = (k % 2 == 0) ? 16'sd32767 : -16'sd32768;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    check(frameDone == 1'b1, "R7", "frameDone after extra samples", int'(frameDone), 1);
    readAll("R7 after overflow");
  endtask

  // R11: out-of-range pair index ignored
  task automatic testOutOfRange();
    @(negedge clk);
    rdReq  = 1'b1;
    rdPair = 11'(PAIRS);
    @(negedge clk);
    check(rdValid == 1'b0, "R11", "rdValid for pair 1072", int'(rdValid), 0);
    rdPair = 11'h7FF;
    @(negedge clk);
    rdReq = 1'b0;
    check(rdValid == 1'b0, "R11", "rdValid for pair 2047", int'(rdValid), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetAndIdle();
    sendFrame(7, 13);
    readAll("frameA");
    testOverflow();
    testOutOfRange();
    sendFrame(29, 5);
    readAll("frameB");
    finishRun();
  end

endmodule